// File: doc/BRIEF.md
# Accumulator ALU with Nibble Flags

This block is the arithmetic stage of a small accumulator-style processor. Each cycle it takes an operation code, a destination operand, a source operand and the current flag byte. One clock later it presents a result word and the next flag byte. The flag byte holds a zero flag, a subtract flag, a half-carry flag and a carry flag.

It performs 8-bit add and subtract, with or without the incoming carry. It also performs a register-pair add of twice the data width, and two operations that set or invert the carry. The half-carry is always the carry or borrow out of the low four bits of the operation. For the wide add it is the carry out of the low twelve bits. For the carry-using operations, the incoming carry takes part in both the nibble check and the full-width check. Operand fetch, register storage and instruction sequencing are the job of the surrounding core.

Top module: `alu8_core`

## Requirements
- R1: Op 0 (add) gives dst[7:0]+src[7:0]. Op 1 (add with carry) adds flags_i[4] as well. The carry flag is bit 8 of that 9-bit sum.
- R2: For ops 0 and 1, the half-carry is set when dst[3:0]+src[3:0] (plus flags_i[4] for op 1) is above 15.
- R3: Op 2 (subtract) gives dst[7:0]-src[7:0]. Op 3 (subtract with borrow) also subtracts flags_i[4]. The carry flag is set when the true difference is negative.
- R4: For ops 2 and 3, the half-carry is set when dst[3:0]-src[3:0] (minus flags_i[4] for op 3) is negative.
- R5: For ops 0 to 3, the zero flag is set exactly when the stored 8-bit result is zero. The subtract flag is cleared for ops 0 and 1 and set for ops 2 and 3.
- R6: Op 4 (wide add) gives the 16-bit sum dst+src. Its half-carry is the carry out of bit 11 and its carry is the carry out of bit 15. The subtract flag is cleared and the zero flag is copied from flags_i[7].
- R7: Op 5 (set carry) sets C and clears N and H. It keeps Z and passes dst through to the result.
- R8: Op 6 (complement carry) inverts flags_i[4] and clears N and H. It keeps Z and passes dst through to the result.
- R9: The flag byte is packed as Z in bit 7, N in bit 6, H in bit 5 and C in bit 4. Bits 3:0 always read zero. For ops 0 to 3, the upper result byte is zero and the upper operand bytes have no effect.
- R10: The outputs are registered, so they show the result of the inputs sampled at the previous clock edge. While rst_n is low, both outputs read zero.
- R11: Op 7 (hold) passes dst through and returns flags_i[7:4] unchanged, with bits 3:0 cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation select (0 add, 1 add+carry, 2 sub, 3 sub+borrow, 4 wide add, 5 set carry, 6 complement carry, 7 hold) |
| dst_i | input | 16 | Destination operand; 8-bit ops use bits 7:0 |
| src_i | input | 16 | Source operand; 8-bit ops use bits 7:0 |
| flags_i | input | 8 | Current flag byte; bit 4 is the carry-in |
| res_o | output | 16 | Registered result |
| flags_o | output | 8 | Registered next flag byte |

## Verification
The bench builds the block with its default widths: an 8-bit data path, a 4-bit nibble, and a 16-bit wide add with its half-carry at bit 11. With these widths, a behavioural model using plain integers reaches every nibble and byte boundary. Directed cases sit exactly on the 15/16 and 255/256 edges, where the carry-in decides the flag. Random operands then cover all eight op codes, including random upper operand bytes that the 8-bit ops must ignore.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_ADC   = 3'd1,
        OP_SUB   = 3'd2,
        OP_SBC   = 3'd3,
        OP_ADDW  = 3'd4,
        OP_SETC  = 3'd5,
        OP_CPLC  = 3'd6,
        OP_HOLD  = 3'd7
    } alu_op_e;

    localparam int FL_Z = 7;
    localparam int FL_N = 6;
    localparam int FL_H = 5;
    localparam int FL_C = 4;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W   = 8,
    parameter int NIB = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         carry_o,
    output logic         half_o
);
    logic [W:0]   full;
    logic [NIB:0] low;

    always_comb begin
        if (sub_i) begin
            full = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
            low  = {1'b0, a_i[NIB-1:0]} - {1'b0, b_i[NIB-1:0]} - {{NIB{1'b0}}, cin_i};
        end else begin
            full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
            low  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, cin_i};
        end
        res_o   = full[W-1:0];
        carry_o = full[W];
        half_o  = low[NIB];
    end
endmodule

// File: rtl/alu8_wide_add.sv
module alu8_wide_add #(
    parameter int W   = 8,
    parameter int NIB = 4
) (
    input  logic [2*W-1:0] a_i,
    input  logic [2*W-1:0] b_i,
    output logic [2*W-1:0] res_o,
    output logic           carry_o,
    output logic           half_o
);
    localparam int WW = 2 * W;
    localparam int HB = WW - NIB;

    logic [WW:0] full;
    logic [HB:0] part;

    always_comb begin
        full    = {1'b0, a_i} + {1'b0, b_i};
        part    = {1'b0, a_i[HB-1:0]} + {1'b0, b_i[HB-1:0]};
        res_o   = full[WW-1:0];
        carry_o = full[WW];
        half_o  = part[HB];
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W   = 8,
    parameter int NIB = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     op_i,
    input  logic [2*W-1:0] dst_i,
    input  logic [2*W-1:0] src_i,
    input  logic [7:0]     flags_i,
    output logic [2*W-1:0] res_o,
    output logic [7:0]     flags_o
);
    localparam int WW = 2 * W;

    typedef struct packed {
        logic [WW-1:0] res;
        logic [7:0]    flags;
    } state_t;

    state_t  st_d, st_q;
    alu_op_e op;

    logic [W-1:0]  narrow_res;
    logic          narrow_c, narrow_h, narrow_cin, narrow_sub;
    logic [WW-1:0] wide_res;
    logic          wide_c, wide_h;

    assign op         = alu_op_e'(op_i);
    assign narrow_sub = (op == OP_SUB) || (op == OP_SBC);
    assign narrow_cin = ((op == OP_ADC) || (op == OP_SBC)) ? flags_i[FL_C] : 1'b0;

    alu8_addsub #(.W(W), .NIB(NIB)) u_addsub (
        .a_i    (dst_i[W-1:0]),
        .b_i    (src_i[W-1:0]),
        .cin_i  (narrow_cin),
        .sub_i  (narrow_sub),
        .res_o  (narrow_res),
        .carry_o(narrow_c),
        .half_o (narrow_h)
    );

    alu8_wide_add #(.W(W), .NIB(NIB)) u_wide (
        .a_i    (dst_i),
        .b_i    (src_i),
        .res_o  (wide_res),
        .carry_o(wide_c),
        .half_o (wide_h)
    );

    always_comb begin
        st_d       = '0;
        st_d.res   = dst_i;
        st_d.flags = {flags_i[7:4], 4'b0000};
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                st_d.res         = {{W{1'b0}}, narrow_res};
                st_d.flags[FL_Z] = (narrow_res == '0);
                st_d.flags[FL_N] = narrow_sub;
                st_d.flags[FL_H] = narrow_h;
                st_d.flags[FL_C] = narrow_c;
            end
            OP_ADDW: begin
                st_d.res         = wide_res;
                st_d.flags[FL_N] = 1'b0;
                st_d.flags[FL_H] = wide_h;
                st_d.flags[FL_C] = wide_c;
            end
            OP_SETC: begin
                st_d.flags[FL_N] = 1'b0;
                st_d.flags[FL_H] = 1'b0;
                st_d.flags[FL_C] = 1'b1;
            end
            OP_CPLC: begin
                st_d.flags[FL_N] = 1'b0;
                st_d.flags[FL_H] = 1'b0;
                st_d.flags[FL_C] = ~flags_i[FL_C];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o   = st_q.res;
    assign flags_o = st_q.flags;

    // R5
    sub_sets_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SUB || op_i == OP_SBC) |=> flags_o[FL_N]);

    // R6
    wide_keeps_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ADDW) |=> (flags_o[FL_Z] == $past(flags_i[FL_Z])) && !flags_o[FL_N]);

    // R7
    setc_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SETC) |=> flags_o[FL_C] && !flags_o[FL_N] && !flags_o[FL_H]
                              && (res_o == $past(dst_i)));

    // R8
    cplc_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CPLC) |=> (flags_o[FL_C] != $past(flags_i[FL_C])) && !flags_o[FL_N]
                              && !flags_o[FL_H]);

    // R9
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i <= OP_SBC) |=> (res_o[WW-1:W] == '0) && (flags_o[3:0] == 4'b0000));

    // R5
    zero_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ADD && dst_i[W-1:0] == '0 && src_i[W-1:0] == '0) |=> (flags_o == 8'h80));
endmodule

// File: tb/alu8_core_test.sv
module alu8_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [15:0] dst_i = 16'h0;
    logic [15:0] src_i = 16'h0;
    logic [7:0]  flags_i = 8'h0;
    logic [15:0] res_o;
    logic [7:0]  flags_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    alu8_core uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .dst_i(dst_i),
        .src_i(src_i), .flags_i(flags_i), .res_o(res_o), .flags_o(flags_o)
    );

    function automatic logic [23:0] model(input int op, input int d, input int s, input int f);
        int r, z, n, h, c, cin, t;
        r = d; z = (f >> 7) & 1; n = (f >> 6) & 1; h = (f >> 5) & 1; c = (f >> 4) & 1;
        cin = (op == 1 || op == 3) ? c : 0;
        case (op)
            0, 1: begin
                t = (d & 255) + (s & 255) + cin;
                h = (((d & 15) + (s & 15) + cin) > 15) ? 1 : 0;
                c = (t > 255) ? 1 : 0; r = t & 255; z = (r == 0) ? 1 : 0; n = 0;
            end
            2, 3: begin
                t = (d & 255) - (s & 255) - cin;
                h = (((d & 15) - (s & 15) - cin) < 0) ? 1 : 0;
                c = (t < 0) ? 1 : 0; r = t & 255; z = (r == 0) ? 1 : 0; n = 1;
            end
            4: begin
                t = d + s;
                h = (((d & 4095) + (s & 4095)) > 4095) ? 1 : 0;
                c = (t > 65535) ? 1 : 0; r = t & 65535; n = 0;
            end
            5: begin c = 1; n = 0; h = 0; end
            6: begin c = 1 - c; n = 0; h = 0; end
            default: ;
        endcase
        return {r[15:0], z[0], n[0], h[0], c[0], 4'b0000};
    endfunction

    function automatic string op_tag(input int op);
        case (op)
            0, 1: return "R1";
            2, 3: return "R3";
            4: return "R6";
            5: return "R7";
            6: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic step(input int op, input int d, input int s, input int f, input string tag);
        logic [23:0] exp;
        @(negedge clk);
        op_i = op[2:0]; dst_i = d[15:0]; src_i = s[15:0]; flags_i = f[7:0];
        exp = model(op, d, s, f);
        @(negedge clk);
        checks++;
        if (res_o !== exp[23:8]) begin
            failures++;
            $display("FAIL %s result op=%0d actual=%h expected=%h", tag, op, res_o, exp[23:8]);
        end
        checks++;
        if (flags_o !== exp[7:0]) begin
            failures++;
            $display("FAIL %s flags op=%0d actual=%h expected=%h", tag, op, flags_o, exp[7:0]);
        end
    endtask

    initial begin
        #4000000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        op_i = 3'd4; dst_i = 16'hFFFF; src_i = 16'h0001; flags_i = 8'hFF;
        repeat (3) @(negedge clk);
        checks++;
        if (res_o !== 16'h0 || flags_o !== 8'h0) begin
            failures++;
            $display("FAIL R10 reset actual=%h/%h expected=0000/00", res_o, flags_o);
        end
        rst_n = 1'b1;
        step(0, 16'h000F, 16'h0001, 8'h00, "R2");
        step(0, 16'h00FF, 16'h0001, 8'h00, "R1");
        step(1, 16'h000E, 16'h0001, 8'h10, "R2");
        step(1, 16'h00FF, 16'h0000, 8'h10, "R1");
        step(0, 16'h0000, 16'h0000, 8'h70, "R5");
        step(2, 16'h0010, 16'h0001, 8'h00, "R4");
        step(2, 16'h0005, 16'h0005, 8'h00, "R5");
        step(2, 16'h0000, 16'h0001, 8'h00, "R3");
        step(3, 16'h0010, 16'h000F, 8'h10, "R4");
        step(3, 16'h0000, 16'h0000, 8'h10, "R3");
        step(4, 16'h0FFF, 16'h0001, 8'h80, "R6");
        step(4, 16'hFFFF, 16'h0001, 8'h00, "R6");
        step(5, 16'h1234, 16'h0000, 8'hE0, "R7");
        step(6, 16'h4321, 16'h0000, 8'h70, "R8");
        step(6, 16'h0000, 16'h0000, 8'h80, "R8");
        step(7, 16'hABCD, 16'h1111, 8'hFF, "R11");
        step(0, 16'hFF01, 16'hAA01, 8'h0F, "R9");
        step(3, 16'h7F20, 16'h3310, 8'h1F, "R9");
        for (int i = 0; i < 600; i++) begin
            int op, d, s, f;
            op = int'($urandom_range(0, 7));
            d  = int'($urandom_range(0, 65535));
            s  = int'($urandom_range(0, 65535));
            f  = int'($urandom_range(0, 255));
            step(op, d, s, f, op_tag(op));
        end
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        checks++;
        if (res_o !== 16'h0 || flags_o !== 8'h0) begin
            failures++;
            $display("FAIL R10 mid-run reset actual=%h/%h expected=0000/00", res_o, flags_o);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule